// File: doc/BRIEF.md
# Branch Target Capability Checker

This block sits between branch resolution and the architectural instruction-capability register. Each branch delivers one input beat with these fields:

- the branch kind (near or far);
- whether the core is running in capability mode;
- the size of the destination code segment and its selector;
- the candidate instruction capability: its tag, its base, its top and the full virtual address it points to.

The block decides whether that capability may become the new instruction pointer. It then returns one result beat, either a commit or a fault with a kind and an error code.

The instruction pointer held here is always the full virtual address, never an offset from a base. A far branch changes only that address. When a branch passes every check, the held address takes the new value in the same cycle that the result is registered. When a branch faults, the held address keeps its old value. A fault on an untagged or out-of-range target is charged to the branch itself.

Both the input and the result are valid/ready streams. An input is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in that same cycle. A result stays stable while `out_valid` is high and `out_ready` is low.

Top module: `branch_tgt_chk`

## Requirements
- R1: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, the result fields stay unchanged.
- R2: An input accepted at one clock edge produces `out_valid` high after that same edge, so the output register adds one cycle of latency.
- R3: A far branch in capability mode whose destination segment is 32-bit (`in_seg32`=1) gives `out_fault`=1 (general protection). `out_err` then equals the destination selector.
- R4: If R3 does not apply and the target tag is clear, the result is `out_fault`=2 (tag fault) with `out_err`=0.
- R5: If neither R3 nor R4 applies and the address is outside the range base ≤ addr < top, the result is `out_fault`=3 (bounds fault) with `out_err`=0. `top` is one bit wider than the address, so a top of 2^AW allows the last address.
- R6: When several faults apply, only one is reported, in the priority order general protection, then tag, then bounds.
- R7: On any fault, `out_commit` is 0 and `cip_addr` keeps its previous value.
- R8: When no fault applies, `out_fault`=0 and `out_commit`=1. `cip_addr` becomes the full target address, for both near and far branches.
- R9: A near branch, or any branch outside capability mode, never raises a general protection fault, whatever the segment size.
- R10: After reset, `out_valid` is 0, `in_ready` is 1 and `cip_addr` equals the parameter RESET_IP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Branch beat present |
| in_ready | output | 1 | Branch beat can be accepted |
| in_far | input | 1 | 1 = far branch, 0 = near branch |
| in_cap_mode | input | 1 | Core is in capability mode |
| in_seg32 | input | 1 | Destination code segment is 32-bit |
| in_seg_sel | input | SW | Destination segment selector |
| in_tag | input | 1 | Target capability tag |
| in_base | input | AW | Target lower bound |
| in_top | input | AW+1 | Target upper bound (exclusive) |
| in_addr | input | AW | Target virtual address |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the result |
| out_commit | output | 1 | Target committed to the instruction pointer |
| out_fault | output | 2 | 0 none, 1 general protection, 2 tag, 3 bounds |
| out_err | output | SW | Fault error code |
| cip_addr | output | AW | Current instruction pointer address |

## Verification
The bench builds the block with AW=12, SW=16 and RESET_IP=0x040. A 12-bit address space lets a top of exactly 0x1000 be driven, which tests the extra top bit against the last address 0xFFF. The narrow width also keeps the targets at base, just below top and at top easy to write out by hand. The consumer stalls on a repeating pattern so that back-pressure and back-to-back beats both occur.

// File: rtl/bt_pkg.sv
package bt_pkg;
  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_GP     = 2'd1,
    FLT_TAG    = 2'd2,
    FLT_BOUNDS = 2'd3
  } bt_fault_e;
endpackage

// File: rtl/bt_bounds_cmp.sv
module bt_bounds_cmp #(
  parameter int AW = 64
) (
  input  logic [AW-1:0] base,
  input  logic [AW:0]   top,
  input  logic [AW-1:0] addr,
  output logic          in_bounds
);
  localparam int XW = AW + 1;
  logic [XW-1:0] addr_x, base_x;
  always_comb begin
    addr_x    = {1'b0, addr};
    base_x    = {1'b0, base};
    in_bounds = (addr_x >= base_x) && (addr_x < top);
  end
endmodule

// File: rtl/bt_fault_sel.sv
module bt_fault_sel
  import bt_pkg::*;
#(
  parameter int SW = 16
) (
  input  logic          far_br,
  input  logic          cap_mode,
  input  logic          seg32,
  input  logic [SW-1:0] sel,
  input  logic          tag,
  input  logic          in_bounds,
  output bt_fault_e     fault,
  output logic [SW-1:0] err
);
  logic gp_hit;
  always_comb begin
    gp_hit = far_br && cap_mode && seg32;
    fault  = FLT_NONE;
    err    = '0;
    if (gp_hit) begin
      fault = FLT_GP;
      err   = sel;
    end else if (!tag) begin
      fault = FLT_TAG;
    end else if (!in_bounds) begin
      fault = FLT_BOUNDS;
    end
  end
endmodule

// File: rtl/bt_out_stage.sv
module bt_out_stage
  import bt_pkg::*;
#(
  parameter int          AW       = 64,
  parameter int          SW       = 16,
  parameter logic [AW-1:0] RESET_IP = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  bt_fault_e     fault,
  input  logic [SW-1:0] err,
  input  logic [AW-1:0] addr,
  input  logic          out_ready,
  output logic          in_ready,
  output logic          out_valid,
  output logic          out_commit,
  output bt_fault_e     out_fault,
  output logic [SW-1:0] out_err,
  output logic [AW-1:0] cip
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_commit <= 1'b0;
      out_fault  <= FLT_NONE;
      out_err    <= '0;
      cip        <= RESET_IP;
    end else begin
      if (load) begin
        out_valid  <= 1'b1;
        out_commit <= (fault == FLT_NONE);
        out_fault  <= fault;
        out_err    <= err;
        if (fault == FLT_NONE) cip <= addr;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  p_stall_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_fault) && $stable(out_err) && $stable(out_commit));
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> out_valid);
  p_cip_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load && fault != FLT_NONE |=> $stable(cip) && !out_commit);
  p_cip_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load && fault == FLT_NONE |=> cip == $past(addr) && out_commit);
endmodule

// File: rtl/branch_tgt_chk.sv
module branch_tgt_chk
  import bt_pkg::*;
#(
  parameter int            AW       = 64,
  parameter int            SW       = 16,
  parameter logic [AW-1:0] RESET_IP = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_far,
  input  logic          in_cap_mode,
  input  logic          in_seg32,
  input  logic [SW-1:0] in_seg_sel,
  input  logic          in_tag,
  input  logic [AW-1:0] in_base,
  input  logic [AW:0]   in_top,
  input  logic [AW-1:0] in_addr,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          out_commit,
  output logic [1:0]    out_fault,
  output logic [SW-1:0] out_err,
  output logic [AW-1:0] cip_addr
);
  logic          in_bounds;
  bt_fault_e     fault_c;
  logic [SW-1:0] err_c;
  bt_fault_e     fault_q;
  logic          load;

  bt_bounds_cmp #(.AW(AW)) u_bounds (
    .base(in_base), .top(in_top), .addr(in_addr), .in_bounds(in_bounds)
  );

  bt_fault_sel #(.SW(SW)) u_sel (
    .far_br(in_far), .cap_mode(in_cap_mode), .seg32(in_seg32), .sel(in_seg_sel),
    .tag(in_tag), .in_bounds(in_bounds), .fault(fault_c), .err(err_c)
  );

  assign load = in_valid && in_ready;

  bt_out_stage #(.AW(AW), .SW(SW), .RESET_IP(RESET_IP)) u_out (
    .clk(clk), .rst_n(rst_n), .load(load), .fault(fault_c), .err(err_c),
    .addr(in_addr), .out_ready(out_ready), .in_ready(in_ready),
    .out_valid(out_valid), .out_commit(out_commit), .out_fault(fault_q),
    .out_err(out_err), .cip(cip_addr)
  );

  assign out_fault = fault_q;

  p_gp_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load && in_far && in_cap_mode && in_seg32 |=> out_fault == 2'd1 && out_err == $past(in_seg_sel));
  p_untagged_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load && !(in_far && in_cap_mode && in_seg32) && !in_tag |=> out_fault == 2'd2);
  p_no_gp_near_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load && (!in_far || !in_cap_mode) |=> out_fault != 2'd1);
  p_quiet_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_fault != 2'd1 |-> out_err == '0);
endmodule

// File: tb/tb_branch_tgt_chk.sv
module tb_branch_tgt_chk;
  localparam int AW = 12;
  localparam int SW = 16;
  localparam logic [AW-1:0] RIP0 = 12'h040;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready;
  logic in_far = 0, in_cap_mode = 0, in_seg32 = 0, in_tag = 0;
  logic [SW-1:0] in_seg_sel = '0;
  logic [AW-1:0] in_base = '0, in_addr = '0;
  logic [AW:0]   in_top = '0;
  logic out_valid, out_ready = 1, out_commit;
  logic [1:0] out_fault;
  logic [SW-1:0] out_err;
  logic [AW-1:0] cip_addr;

  always #2 clk = ~clk;

  branch_tgt_chk #(.AW(AW), .SW(SW), .RESET_IP(RIP0)) dut (.*);

  typedef struct packed {
    logic          commit;
    logic [1:0]    fault;
    logic [SW-1:0] err;
    logic [AW-1:0] cip;
  } exp_t;

  exp_t exp_q[$];
  string tag_q[$];
  logic [AW-1:0] model_cip = RIP0;
  int n_chk = 0, n_bad = 0;
  bit stall_mode = 0;
  int cyc = 0;

  task automatic check(string req, logic [63:0] act, logic [63:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  // out_ready changes just after the rising edge, stable at the falling edge
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 out_ready = stall_mode ? (cyc % 3 != 0) : 1'b1;
  end

  task automatic send(string req, bit far, bit cm, bit s32, logic [SW-1:0] sel,
                      bit tg, logic [AW-1:0] b, logic [AW:0] t, logic [AW-1:0] a);
    exp_t e;
    bit ok;
    e.err = '0;
    if (far && cm && s32) begin e.fault = 2'd1; e.err = sel; end
    else if (!tg) e.fault = 2'd2;
    else if (!({1'b0, a} >= {1'b0, b} && {1'b0, a} < t)) e.fault = 2'd3;
    else e.fault = 2'd0;
    e.commit = (e.fault == 2'd0);
    if (e.commit) model_cip = a;
    e.cip = model_cip;
    exp_q.push_back(e);
    tag_q.push_back(req);
    in_valid = 1; in_far = far; in_cap_mode = cm; in_seg32 = s32; in_seg_sel = sel;
    in_tag = tg; in_base = b; in_top = t; in_addr = a;
    while (1) begin
      ok = in_ready;
      @(negedge clk);
      if (ok) break;
    end
    in_valid = 0;
  endtask

  // monitor / scoreboard
  bit prev_stall = 0;
  exp_t prev_pl;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall && out_valid)
        check("R1 hold", {out_commit, out_fault, out_err}, {prev_pl.commit, prev_pl.fault, prev_pl.err});
      if (out_valid) check("R1 ready", in_ready, out_ready);
      prev_stall = out_valid && !out_ready;
      prev_pl.commit = out_commit; prev_pl.fault = out_fault; prev_pl.err = out_err;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL R2: unexpected result actual fault %0d expected none", out_fault);
        end else begin
          exp_t e;
          string r;
          e = exp_q.pop_front();
          r = tag_q.pop_front();
          check({r, " fault"}, out_fault, e.fault);
          check({r, " err"}, out_err, e.err);
          check({r, " commit"}, out_commit, e.commit);
          check({r, " cip"}, cip_addr, e.cip);
        end
      end
    end
  end

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 out_valid", out_valid, 0);
    check("R10 cip", cip_addr, RIP0);
    check("R10 in_ready", in_ready, 1);
    rst_n = 1;
    @(negedge clk);
    // R2: result one cycle after acceptance
    send("R2 R8 R9 near cap seg32", 0, 1, 1, 16'h0011, 1, 12'h100, 13'h0200, 12'h150);
    check("R2 latency", out_valid, 1);
    @(negedge clk);
    send("R9 far noncap seg32", 1, 0, 1, 16'h0012, 1, 12'h100, 13'h0200, 12'h180);
    send("R3 gp", 1, 1, 1, 16'h002B, 1, 12'h100, 13'h0200, 12'h150);
    send("R4 untagged", 0, 1, 0, 16'h0005, 0, 12'h100, 13'h0200, 12'h150);
    send("R5 addr at top", 0, 1, 0, 16'h0, 1, 12'h100, 13'h0200, 12'h200);
    send("R5 addr below base", 1, 0, 0, 16'h0, 1, 12'h100, 13'h0200, 12'h0FF);
    send("R5 R8 addr at base", 0, 0, 0, 16'h0, 1, 12'h100, 13'h0200, 12'h100);
    send("R5 R8 full top", 0, 1, 0, 16'h0, 1, 12'h000, 13'h1000, 12'hFFF);
    send("R6 gp over tag bounds", 1, 1, 1, 16'h0077, 0, 12'h100, 13'h0200, 12'h900);
    send("R6 tag over bounds", 1, 1, 0, 16'h0077, 0, 12'h100, 13'h0200, 12'h900);
    send("R7 fault keeps cip", 1, 1, 0, 16'h0, 1, 12'h300, 13'h0400, 12'h2FF);
    send("R8 far cap seg64", 1, 1, 0, 16'h0099, 1, 12'h300, 13'h0400, 12'h3FF);
    // back-pressure phase
    stall_mode = 1;
    for (int i = 0; i < 24; i++)
      send((i % 3 == 0) ? "R1 R3 stall gp" : (i % 3 == 1) ? "R1 R8 stall pass" : "R1 R5 stall oob",
           (i % 3 == 0), 1, (i % 3 == 0), 16'(i + 16'h0100), 1,
           12'h200, 13'h0800, (i % 3 == 2) ? 12'h800 : 12'(12'h200 + i * 8));
    while (exp_q.size() != 0) @(negedge clk);
    stall_mode = 0;
    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule